// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a differential sampled-input converter that resolves a 12-bit word by successive approximation. It holds the sample network in track mode and closes the comparator offset-nulling switches for a minimum number of clock cycles. A conversion starts when the chip is selected and a start is requested together. The block then opens the nulling switches, puts the sample network into hold, and walks a trial code from the top bit down to the bottom bit, one decision per clock. The trial code drives an external capacitive DAC. A single comparator bit reports whether the held input is above the DAC level.

After the final decision the block copies the resolved word into an output latch and returns to track mode. A start request that arrives during a conversion is dropped. A start request that arrives before the minimum track time has run out is remembered, and it fires as soon as that time is met. The DAC, the comparator and the reference lie outside this block. The testbench models the comparator.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion is accepted only in a cycle where `sel_i` and `start_i` are both 1. Either input alone never raises `busy_o`.
- R2: The accepted conversion begins with the approximation register cleared. In the first convert cycle `trial_o` equals only the top bit (12'h800).
- R3: A start request in any convert cycle is ignored and not remembered. After the conversion ends, `busy_o` stays 0 until a new request arrives.
- R4: Bits are tried one per clock, from bit 11 down to bit 0, so there are 12 convert cycles. In convert cycle k (k = 0..11), `trial_o` holds the bits already decided above bit 11-k, bit 11-k set to 1, and zeros below it.
- R5: A trial bit is kept when `cmp_i` = 1 in its cycle and cleared when `cmp_i` = 0. With a comparator that returns 1 when the input code is greater than or equal to `trial_o`, the result equals the input code for every code from 0 to 4095.
- R6: In the acquire phase `sample_o` = 1 (inputs tracked) and `zero_o` = 1 (nulling closed). The acquire phase lasts at least `ACQ_CYCLES` clock cycles after reset or after the end of a conversion before a conversion can start.
- R7: In every convert cycle `sample_o` = 0 (hold) and `zero_o` = 0 (nulling open).
- R8: `result_o` is loaded with the final word at the end of the last decision. It keeps its previous value for the whole of a conversion and while idle. It is 0 after reset.
- R9: `busy_o` rises in the cycle after an accepted request. It falls in the same cycle that `result_o` shows the new word. For a request made with the acquire time already met, `busy_o` is high for exactly 12 cycles.
- R10: A request made before the acquire time is met keeps `busy_o` high, and the conversion starts as soon as the minimum is reached. `sample_o` is then high for exactly `ACQ_CYCLES` cycles after the previous conversion ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high |
| start_i | input | 1 | Convert request, active high |
| cmp_i | input | 1 | Comparator: 1 when held input is at or above the DAC level |
| trial_o | output | 12 | Trial code driven to the capacitive DAC |
| sample_o | output | 1 | 1 = sample switches tracking, 0 = hold |
| zero_o | output | 1 | 1 = comparator nulling switches closed |
| busy_o | output | 1 | Conversion pending or in progress |
| result_o | output | 12 | Latched result of the last conversion |

## Verification
The hardest case to reach from the ports is a request that lands in the first few acquire cycles right after a conversion. It has to be held through the remaining track time and must not shorten it. The bench reaches this case by raising the request on the very cycle that `busy_o` is first seen low. It then counts the cycles that `sample_o` stays high before the next hold. The same runs also pulse `start_i` in the middle of a conversion, to show that the dropped request does not come back once the acquire phase resumes.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    PH_ACQ  = 1'b0,
    PH_CONV = 1'b1
  } sar_phase_e;

  // One decision: keep the probed bit when the comparator is high.
  function automatic logic [31:0] decide(input logic [31:0] code,
                                         input logic [31:0] probe,
                                         input logic        above);
    return above ? (code | probe) : code;
  endfunction

  // Code presented to the DAC: decided bits plus the bit under trial.
  function automatic logic [31:0] trial_of(input logic [31:0] code,
                                           input logic [31:0] probe);
    return code | probe;
  endfunction

endpackage

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic acq_ok_o
);
  localparam int CW  = (ACQ_CYCLES < 2) ? 1 : $clog2(ACQ_CYCLES);
  localparam int LIM = (ACQ_CYCLES < 1) ? 0 : ACQ_CYCLES - 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CW'(LIM)) cnt_q <= cnt_q + CW'(1);
  end

  assign acq_ok_o = (cnt_q == CW'(LIM));

  AST_ACQ_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= LIM);  // R6
  AST_ACQ_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));  // R6
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_o,
  output logic             last_o,
  output logic [NBITS-1:0] final_o
);
  localparam logic [NBITS-1:0] TOP_HOT = NBITS'(1) << (NBITS - 1);

  logic [NBITS-1:0] code_q;
  logic [NBITS-1:0] probe_q;
  logic [NBITS-1:0] code_nx;
  logic [31:0]      dec_w;
  logic [31:0]      tri_w;

  always_comb begin
    dec_w   = decide(32'(code_q), 32'(probe_q), cmp_i);
    tri_w   = trial_of(32'(code_q), 32'(probe_q));
    code_nx = dec_w[NBITS-1:0];
    trial_o = tri_w[NBITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      probe_q <= '0;
    end else if (load_i) begin
      code_q  <= '0;
      probe_q <= TOP_HOT;
    end else if (step_i) begin
      code_q  <= code_nx;
      probe_q <= probe_q >> 1;
    end
  end

  assign last_o  = probe_q[0];
  assign final_o = code_nx;

  AST_PROBE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_q));  // R4
  AST_LOAD_TOP_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (trial_o == TOP_HOT));  // R2
  AST_STEP_ONE_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_o) |=> ($countones(probe_q) == 1));  // R4
  AST_DECIDED_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> ((code_q & $past(code_q)) == $past(code_q)));  // R5
endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NBITS-1:0] d_i,
  output logic [NBITS-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(d_i)));  // R8
  AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));  // R8
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS      = 12,
  parameter int ACQ_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_o,
  output logic             sample_o,
  output logic             zero_o,
  output logic             busy_o,
  output logic [NBITS-1:0] result_o
);
  sar_phase_e       phase_q;
  logic             pend_q;
  logic             req_w;
  logic             in_acq_w;
  logic             acq_ok_w;
  logic             conv_go_w;
  logic             step_w;
  logic             last_w;
  logic             done_w;
  logic [NBITS-1:0] final_w;

  assign req_w     = sel_i & start_i;
  assign in_acq_w  = (phase_q == PH_ACQ);
  assign conv_go_w = in_acq_w & (pend_q | req_w) & acq_ok_w;
  assign step_w    = ~in_acq_w;
  assign done_w    = step_w & last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACQ;
      pend_q  <= 1'b0;
    end else begin
      if (conv_go_w)   phase_q <= PH_CONV;
      else if (done_w) phase_q <= PH_ACQ;
      if (!in_acq_w || conv_go_w) pend_q <= 1'b0;
      else if (req_w)             pend_q <= 1'b1;
    end
  end

  sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (step_w),
    .acq_ok_o (acq_ok_w)
  );

  sar_bit_engine #(.NBITS(NBITS)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (conv_go_w),
    .step_i  (step_w),
    .cmp_i   (cmp_i),
    .trial_o (trial_o),
    .last_o  (last_w),
    .final_o (final_w)
  );

  sar_out_latch #(.NBITS(NBITS)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (done_w),
    .d_i    (final_w),
    .q_o    (result_o)
  );

  assign sample_o = in_acq_w;
  assign zero_o   = in_acq_w;
  assign busy_o   = ~in_acq_w | pend_q;

  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(sel_i && start_i));  // R1
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_acq_w && req_w && !done_w) |=> (!pend_q && !sample_o));  // R3
  AST_HOLD_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_o) |-> $past(acq_ok_w));  // R6
  AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(result_o));  // R8
  AST_BUSY_ENDS_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> (!busy_o && sample_o && zero_o));  // R9
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 12;
  localparam int ACQ = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          start = 1'b0;
  logic [NB-1:0] vin = '0;
  logic          cmp;
  logic [NB-1:0] trial, result;
  logic          sample, zero, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp = (vin >= trial);

  sar_conv_ctrl #(.NBITS(NB), .ACQ_CYCLES(ACQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(start), .cmp_i(cmp),
    .trial_o(trial), .sample_o(sample), .zero_o(zero), .busy_o(busy),
    .result_o(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One conversion; the request is raised at the current negedge.
  // mid_pulse: pulse start in convert cycle 5. early: request made right after a prior end.
  task automatic convert(input int v, input bit mid_pulse, input bit early, input bit fine);
    int k;
    int acq_seen;
    bit walk_ok, hold_ok, phase_ok;
    logic [NB-1:0] prev;
    int mask, exp_t;
    prev = result;
    vin = NB'(v);
    sel = 1'b1;
    start = 1'b1;
    acq_seen = 0;
    if (early) begin
      while (sample) begin
        acq_seen++;
        @(negedge clk);
        start = 1'b0;
      end
      check(acq_seen == ACQ, "R10 held request waits out acquire", acq_seen, ACQ);
    end else begin
      @(negedge clk);
      start = 1'b0;
    end
    k = 0; walk_ok = 1; hold_ok = 1; phase_ok = 1;
    while (busy && k < 40) begin
      mask  = (1 << (NB - k)) - 1;
      exp_t = (v & ~mask) | (1 << (NB - 1 - k));
      if (k < NB && int'(trial) != exp_t) walk_ok = 0;
      if (result != prev) hold_ok = 0;
      if (sample || zero) phase_ok = 0;
      if (fine && k == 0)
        check(trial == 12'h800, "R2 first trial is top bit only", trial, 12'h800);
      start = (mid_pulse && k == 5);
      k++;
      @(negedge clk);
    end
    start = 1'b0;
    if (fine) begin
      check(walk_ok, "R4 trial walk top to bottom", walk_ok, 1);
      check(hold_ok, "R8 result held during conversion", hold_ok, 1);
      check(phase_ok, "R7 hold and nulling open in convert", phase_ok, 1);
      check(k == NB, "R9 busy length", k, NB);
    end
    check(int'(result) == v, "R5 converted code", result, v);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && result == 0 && trial == 0, "R8 reset state", result, 0);
    check(sample && zero, "R6 acquire switches after reset", {sample, zero}, 3);

    // R1: either input alone does nothing.
    sel = 1'b0; start = 1'b1;
    begin
      bit stay = 1;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy || !sample) stay = 0; end
      sel = 1'b1; start = 1'b0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy || !sample) stay = 0; end
      check(stay, "R1 start needs select and request", stay, 1);
    end

    // R5 boundaries plus full walk checks.
    convert(4095, 0, 0, 1); wait_neg(ACQ);
    convert(0, 0, 0, 1);    wait_neg(ACQ);
    convert(2730, 0, 0, 1); wait_neg(ACQ);

    // R3: pulse mid-conversion is dropped.
    convert(1365, 1, 0, 1);
    begin
      bit idle = 1;
      for (int i = 0; i < ACQ + 6; i++) begin @(negedge clk); if (busy || !sample) idle = 0; end
      check(idle, "R3 mid-conversion request ignored", idle, 1);
      check(result == 12'd1365, "R3 result untouched", result, 1365);
    end

    // R10: request the moment busy drops; held until acquire satisfied.
    convert(100, 0, 0, 1);
    convert(3000, 0, 1, 1);
    convert(7, 0, 1, 1);
    wait_neg(ACQ);

    // Exhaustive sweep of every code.
    for (int v = 0; v < (1 << NB); v++) begin
      convert(v, 0, 0, 0);
      wait_neg(ACQ);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule